// File: doc/BRIEF.md
# Timing-Track Sector Mark Decoder

This block sits behind the read channel of a rotating store's timing track. It receives one recovered bit per strobe and looks for 4-bit marker characters. A marker only counts when a run of zero bits comes before it. The block recognises three markers: the once-per-revolution index mark, the sector mark of the outer recording zone and the sector mark of the inner recording zone.

Both zones share the one track. The block therefore keeps an independent sector count for each zone. It reports the count for whichever zone the caller has selected, and it strobes when the selected zone reaches a new sector.

At each index mark both counts return to zero. The block also checks that the previous revolution carried the configured number of sector marks for each zone. Any malformed marker, or any revolution with the wrong number of sector marks, produces a one-cycle framing-error strobe.

Top module: `sector_mark_decoder`

## Requirements
- R1: After reset, `index_pulse`, `sector_pulse` and `frame_err` are low and `sector_num` is 0.
- R2: The bit pattern 1,1,1,1 is the index mark. When it is received after the required zero gap, `index_pulse` is high for exactly the one clock cycle after the edge that accepts its fourth bit. In that same cycle `sector_num` reads 0 for both zones.
- R3: The bit pattern 1,0,1,1 is the outer-zone sector mark. Each one advances the outer count by one. `sector_pulse` fires in the cycle after the fourth bit only while `zone_sel` is 1 (outer).
- R4: The bit pattern 1,1,0,1 is the inner-zone sector mark. Each one advances the inner count by one. `sector_pulse` fires in the cycle after the fourth bit only while `zone_sel` is 0 (inner).
- R5: A sector mark of the unselected zone produces no `sector_pulse` and leaves `sector_num` unchanged. Its own zone's count still advances, and this shows on `sector_num` once `zone_sel` is switched to that zone.
- R6: A character starts only at a 1 bit that follows at least GAP_MIN consecutive accepted zero bits. A 1 bit that arrives after a shorter zero run is ignored and restarts the zero-run count. Bits inside a character do not count as gap zeros.
- R7: A 4-bit window that starts with 1, follows a valid gap and matches none of the three marks raises `frame_err` for one cycle. It produces no index or sector strobe and changes no count.
- R8: At every index mark after the first one since reset, `frame_err` is raised together with `index_pulse` if the inner count differs from INNER_SECTORS or the outer count differs from OUTER_SECTORS.
- R9: Cycles with `bit_valid` low are ignored, whatever value `bit_in` carries.
- R10: Each count is ceil(log2(max(INNER_SECTORS,OUTER_SECTORS)+1)) bits wide and saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Timing-track bit |
| zone_sel | input | 1 | Selects the reported zone: 0 inner, 1 outer |
| index_pulse | output | 1 | One-cycle strobe on an index mark |
| sector_pulse | output | 1 | One-cycle strobe on a sector mark of the selected zone |
| sector_num | output | CW | Sector count of the selected zone since the last index |
| frame_err | output | 1 | One-cycle strobe on a malformed mark or a wrong per-revolution count |

## Verification
The embedded assertions check every cycle that the index and sector strobes are mutually exclusive and that every strobe follows an accepted bit. They also check that `sector_num` is zero with an index strobe, steps by exactly one with a sector strobe, and otherwise holds while the zone stays fixed. Which window decodes to which mark, the gap rule, the handling of marks from the unselected zone, saturation and the per-revolution count check all depend on the incoming bit sequence. Only the bench scenarios can show these: a sweep of every window that starts with 1 in both zones, short-gap and stalled streams, and complete and short revolutions.

// File: rtl/sector_mark_decoder.sv
module sector_mark_decoder #(
  parameter int INNER_SECTORS = 12,
  parameter int OUTER_SECTORS = 20,
  parameter int GAP_MIN       = 4,
  localparam int MAXN = (INNER_SECTORS > OUTER_SECTORS) ? INNER_SECTORS : OUTER_SECTORS,
  localparam int CW   = $clog2(MAXN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic          zone_sel,
  output logic          index_pulse,
  output logic          sector_pulse,
  output logic [CW-1:0] sector_num,
  output logic          frame_err
);
  localparam int GW = $clog2(GAP_MIN + 1);
  localparam logic [GW-1:0] GAP_V  = GW'(GAP_MIN);
  localparam logic [CW-1:0] CNT_MX = '1;
  localparam logic [CW-1:0] IN_N   = CW'(INNER_SECTORS);
  localparam logic [CW-1:0] OUT_N  = CW'(OUTER_SECTORS);
  localparam logic [3:0] MK_IDX = 4'b1111;
  localparam logic [3:0] MK_OUT = 4'b1011;
  localparam logic [3:0] MK_IN  = 4'b1101;

  logic [GW-1:0] zrun;
  logic          busy, seen;
  logic [1:0]    pos;
  logic [2:0]    win;
  logic [CW-1:0] cnt_in, cnt_out;

  wire       start  = bit_valid && !busy && bit_in && (zrun >= GAP_V);
  wire       done   = bit_valid && busy && (pos == 2'd3);
  wire [3:0] code   = {win, bit_in};
  wire       hit_ix = done && (code == MK_IDX);
  wire       hit_o  = done && (code == MK_OUT);
  wire       hit_i  = done && (code == MK_IN);
  wire       bad    = done && !(hit_ix || hit_o || hit_i);
  wire       cnterr = hit_ix && seen && ((cnt_in != IN_N) || (cnt_out != OUT_N));

  assign sector_num = zone_sel ? cnt_out : cnt_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun <= '0; busy <= 1'b0; pos <= '0; win <= '0; seen <= 1'b0;
      cnt_in <= '0; cnt_out <= '0;
      index_pulse <= 1'b0; sector_pulse <= 1'b0; frame_err <= 1'b0;
    end else begin
      if (bit_valid && !busy) begin
        if (bit_in) zrun <= '0;
        else if (zrun < GAP_V) zrun <= zrun + 1'b1;
      end
      if (start) begin
        busy <= 1'b1; pos <= 2'd1; win <= 3'b001;
      end else if (done) begin
        busy <= 1'b0; pos <= '0; zrun <= '0;
      end else if (bit_valid && busy) begin
        pos <= pos + 1'b1; win <= {win[1:0], bit_in};
      end
      if (hit_ix) begin
        cnt_in <= '0; cnt_out <= '0; seen <= 1'b1;
      end
      if (hit_o && cnt_out != CNT_MX) cnt_out <= cnt_out + 1'b1;
      if (hit_i && cnt_in != CNT_MX) cnt_in <= cnt_in + 1'b1;
      index_pulse  <= hit_ix;
      sector_pulse <= zone_sel ? hit_o : hit_i;
      frame_err    <= bad || cnterr;
    end
  end

  // R2
  mark_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(index_pulse && sector_pulse));
  // R2
  index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    index_pulse |-> sector_num == '0);
  // R9
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (index_pulse || sector_pulse || frame_err) |-> $past(bit_valid));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_pulse && $stable(zone_sel) && $past(sector_num) != CNT_MX)
      |-> sector_num == $past(sector_num) + 1'b1);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sector_pulse && !index_pulse && $stable(zone_sel)) |-> $stable(sector_num));
endmodule

// File: tb/sim_sector_mark_decoder.sv
`timescale 1ns/1ps
module sim_sector_mark_decoder;
  localparam int NI = 3, NO = 5, GAP = 4;
  localparam int W = $clog2(((NI > NO) ? NI : NO) + 1);
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, zone_sel = 1'b0;
  logic index_pulse, sector_pulse, frame_err;
  logic [W-1:0] sector_num;
  int tests = 0, fails = 0;
  int ein = 0, eout = 0;
  bit seen = 0;

  always #2.5 clk = ~clk;

  sector_mark_decoder #(.INNER_SECTORS(NI), .OUTER_SECTORS(NO), .GAP_MIN(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in), .zone_sel(zone_sel),
    .index_pulse(index_pulse), .sector_pulse(sector_pulse), .sector_num(sector_num),
    .frame_err(frame_err));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0;
  endtask

  task automatic send_char(input logic [3:0] c, input int gap);
    for (int i = 0; i < gap; i++) send_bit(1'b0);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
  endtask

  // model from R2..R4, R7, R8, R10
  task automatic check_char(input logic [3:0] c, input string tag);
    int xi, xs, xf;
    xi = 0; xs = 0; xf = 0;
    if (c == 4'b1111) begin
      xi = 1; xf = (seen && (ein != NI || eout != NO)) ? 1 : 0;
      ein = 0; eout = 0; seen = 1;
    end else if (c == 4'b1011) begin
      if (eout < CMAX) eout++;
      xs = zone_sel;
    end else if (c == 4'b1101) begin
      if (ein < CMAX) ein++;
      xs = !zone_sel;
    end else xf = 1;
    send_char(c, GAP);
    chk({tag, " index"}, index_pulse, xi);
    chk({tag, " sector"}, sector_pulse, xs);
    chk({tag, " ferr"}, frame_err, xf);
    chk({tag, " num"}, sector_num, zone_sel ? eout : ein);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 index", index_pulse, 0);
    chk("R1 sector", sector_pulse, 0);
    chk("R1 ferr", frame_err, 0);
    chk("R1 num", sector_num, 0);

    // R2..R4, R7 sweep of every window starting with 1, both zones
    for (int z = 0; z < 2; z++) begin
      zone_sel = z[0];
      for (int c = 8; c < 16; c++) check_char(c[3:0], "R7/R2/R3/R4 sweep");
    end

    // R5: unselected-zone marks show after switching zone
    check_char(4'b1111, "R2 idx");
    zone_sel = 1'b0;
    check_char(4'b1011, "R5 outer while inner");
    check_char(4'b1011, "R5 outer while inner");
    zone_sel = 1'b1;
    #1 chk("R5 switch num", sector_num, eout);

    // R8: full revolution, then a short one
    check_char(4'b1111, "R8 start");
    for (int k = 0; k < NO; k++) check_char(4'b1011, "R3 rev");
    for (int k = 0; k < NI; k++) check_char(4'b1101, "R4 rev");
    check_char(4'b1111, "R8 good rev");
    for (int k = 0; k < NO - 1; k++) check_char(4'b1011, "R3 short");
    for (int k = 0; k < NI; k++) check_char(4'b1101, "R4 short");
    check_char(4'b1111, "R8 short rev");

    // R6: short gaps never start a character
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    chk("R6 no index", index_pulse, 0);
    chk("R6 no ferr", frame_err, 0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    chk("R6 no sector", sector_pulse, 0);
    chk("R6 num", sector_num, eout);
    check_char(4'b1011, "R6 after gap");

    // R9: stalled bits with bit_in high inside and before a char
    for (int i = 0; i < GAP; i++) send_bit(1'b0);
    bit_in = 1'b1; repeat (3) @(negedge clk); bit_in = 1'b0;
    send_bit(1'b1);
    bit_in = 1'b1; repeat (3) @(negedge clk); bit_in = 1'b0;
    send_bit(1'b0); send_bit(1'b1);
    chk("R9 no early", sector_pulse, 0);
    send_bit(1'b1);
    if (eout < CMAX) eout++;
    chk("R9 sector", sector_pulse, 1);
    chk("R9 num", sector_num, eout);
    chk("R9 ferr", frame_err, 0);

    // R10 saturation
    for (int k = 0; k < CMAX + 3; k++) check_char(4'b1011, "R10 sat");
    chk("R10 final", sector_num, CMAX);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule